// File: doc/BRIEF.md
# Routed Multi-Core Interrupt Controller

This block gathers 32 interrupt sources and steers each of them to one or more of four processor cores, and on each chosen core to one of four parent interrupt lines. Every source passes through a two-flop synchronizer. It is then qualified as level-sensitive or edge-sensitive, with a programmable active sense. Edge-mode sources hold a sticky pending flag until software clears it.

Software programs the block over a simple synchronous register bus with byte lanes. Each source has its own routing byte: the low nibble picks the cores and the high nibble picks the parent line. A shared word turns sources on and off through separate set and clear addresses. Two more words hold the sense and the trigger mode of each source. Each core has its own status word, which shows the enabled, active sources routed to that core, so the interrupt handler can find out what fired.

Top module: `irq_router`

## Requirements
- R1: After reset every routing byte, the enable word, the sense word and the mode word read zero, so every source is level-sensitive and active-high. The read data register reads zero and every parent output is low.
- R2: The routing byte of source n sits at byte address n (0x00 to 0x1F). Within a 32-bit word, byte lane b holds source 4·w+b. Only lanes whose byte enable is set are written. Bits 3:0 of the byte are the core mask and bits 7:4 are the parent-line bits.
- R3: A write to 0x28 sets the enable bits where the write data is 1. A write to 0x2C clears them. Zero bits leave the enable unchanged. Reads of 0x24, 0x28 and 0x2C all return the enable word.
- R4: In level mode (mode bit 0), a source is active while its synchronized input differs from its sense bit at 0x30. Sense 0 means active-high and sense 1 means active-low.
- R5: In edge mode (mode bit 1 at 0x34), a source sets a sticky pending flag on a rising edge when its sense bit is 0, and on a falling edge when it is 1. The flag stays set until a write to 0x2C with that bit set clears it, and the clear wins over a new edge in the same cycle. In edge mode the source is active while the flag is set.
- R6: An input change is seen by the level logic after the second rising clock edge, and it reaches the parent outputs in that same cycle. In edge mode the pending flag, and the output with it, follows one edge later.
- R7: parent_o[4·c+k] is high when any enabled, active source has core bit c and line bit k set in its routing byte. A source with several core bits set drives every one of those cores.
- R8: A read of 0x40 + 8·c returns the status word of core c. Bit n of that word is high when source n is enabled, active and has core bit c set.
- R9: Read data is registered. It appears in the cycle after a read request and holds until the next read. Reads of unmapped addresses return zero, and writes to the status words or to unmapped addresses change nothing.
- R10: Writes to the enable-set, enable-clear, sense and mode words act only on the byte lanes whose byte enables are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Interrupt sources, asynchronous |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 8 | Byte address |
| be_i | input | 4 | Byte enables for writes |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| parent_o | output | 16 | Parent lines, index 4·core + line |

## Verification
The assertions check, on every cycle, the properties that involve only a few signals. A full enable-clear empties the enable word. A set write leaves its bits set, and a write with no byte enables leaves the enable alone. A pending flag can rise only while its source is in edge mode, and it is gone after a clear. No parent line is high while the enable word is zero, and the read data holds between reads. The bench's reference model compares every cycle and shows the rest, which needs a whole sequence of stimulus. That covers the two- and three-edge latencies, the selection of rising or falling edges and the stickiness of pending flags, the fan-out of one source to several cores, the per-core status words, and the fact that writes to read-only addresses are ignored.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int NSRC   = 32;
  localparam int NCORE  = 4;
  localparam int NLINE  = 4;
  localparam int RW     = NCORE + NLINE;
  localparam int NPAR   = NCORE * NLINE;
  localparam int AW     = 8;
  localparam int DW     = 32;
  localparam int NLANE  = DW / 8;
  localparam int WAW    = AW - 2;
  localparam int ROUTE_WORDS = NSRC / NLANE;
  localparam int SYNC_STAGES = 2;

  localparam logic [WAW-1:0] W_EN    = WAW'(6'h09);
  localparam logic [WAW-1:0] W_SET   = WAW'(6'h0A);
  localparam logic [WAW-1:0] W_CLR   = WAW'(6'h0B);
  localparam logic [WAW-1:0] W_POL   = WAW'(6'h0C);
  localparam logic [WAW-1:0] W_TRIG  = WAW'(6'h0D);
  localparam logic [WAW-1:0] W_STAT0 = WAW'(6'h10);

  // line select in the high nibble, core mask in the low nibble
  typedef struct packed {
    logic [NLINE-1:0] line;
    logic [NCORE-1:0] core;
  } route_t;

  function automatic logic [DW-1:0] lane_mask(input logic [NLANE-1:0] be);
    logic [DW-1:0] m;
    for (int b = 0; b < NLANE; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction
endpackage

// File: rtl/irq_src_cond.sv
module irq_src_cond
  import irq_router_pkg::*;
#(
  parameter int N      = NSRC,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic [N-1:0] pol_i,
  input  logic [N-1:0] trig_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] act_o,
  output logic [N-1:0] pend_o
);
  logic [STAGES-1:0][N-1:0] sync_q;
  logic [N-1:0] prev_q, lvl, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= src_i;
      for (int s = 1; s < STAGES; s++) sync_q[s] <= sync_q[s-1];
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl = sync_q[STAGES-1];
  // edge picked from raw samples so a sense change never fakes an edge
  assign hit = ((lvl & ~prev_q) & ~pol_i) | ((~lvl & prev_q) & pol_i);

  for (genvar i = 0; i < N; i++) begin : g_pend
    logic pend_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                pend_q <= 1'b0;
      else if (clr_i[i])          pend_q <= 1'b0;
      else if (trig_i[i] && hit[i]) pend_q <= 1'b1;
    end
    assign pend_o[i] = pend_q;
    assign act_o[i]  = trig_i[i] ? pend_q : (lvl[i] ^ pol_i[i]);
  end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_router_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [AW-1:0]                addr_i,
  input  logic [NLANE-1:0]             be_i,
  input  logic [DW-1:0]                wdata_i,
  input  logic [NCORE-1:0][NSRC-1:0]   stat_i,
  output logic [DW-1:0]                rdata_o,
  output route_t [NSRC-1:0]            route_o,
  output logic [NSRC-1:0]              en_o,
  output logic [NSRC-1:0]              pol_o,
  output logic [NSRC-1:0]              trig_o,
  output logic [NSRC-1:0]              clr_o
);
  logic [WAW-1:0] widx;
  logic [1:0]     unused_lsb;
  logic           wr, rd;
  logic [DW-1:0]  wmask, wbits, rd_d, rdata_q;
  logic [NSRC-1:0] en_q, pol_q, trig_q;
  route_t         route_q [NSRC];

  assign widx       = addr_i[AW-1:2];
  assign unused_lsb = addr_i[1:0];
  assign wr         = req_i & we_i;
  assign rd         = req_i & ~we_i;
  assign wmask      = lane_mask(be_i);
  assign wbits      = wdata_i & wmask;

  for (genvar i = 0; i < NSRC; i++) begin : g_route
    localparam logic [WAW-1:0] WI = WAW'(i / NLANE);
    localparam int LANE = i % NLANE;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) route_q[i] <= '0;
      else if (wr && widx == WI && be_i[LANE]) route_q[i] <= route_t'(wdata_i[8*LANE +: 8]);
    end
    assign route_o[i] = route_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      trig_q <= '0;
    end else if (wr) begin
      case (widx)
        W_SET:   en_q   <= en_q | wbits;
        W_CLR:   en_q   <= en_q & ~wbits;
        W_POL:   pol_q  <= (pol_q & ~wmask) | wbits;
        W_TRIG:  trig_q <= (trig_q & ~wmask) | wbits;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && widx == W_CLR) ? wbits : '0;

  always_comb begin
    rd_d = '0;
    if (widx < WAW'(ROUTE_WORDS)) begin
      for (int b = 0; b < NLANE; b++)
        rd_d[8*b +: 8] = route_q[int'(widx[$clog2(ROUTE_WORDS)-1:0]) * NLANE + b];
    end else begin
      case (widx)
        W_EN, W_SET, W_CLR: rd_d = en_q;
        W_POL:              rd_d = pol_q;
        W_TRIG:             rd_d = trig_q;
        default:            ;
      endcase
      for (int c = 0; c < NCORE; c++)
        if (widx == W_STAT0 + WAW'(2 * c)) rd_d = stat_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign trig_o  = trig_q;
endmodule

// File: rtl/irq_fanout.sv
module irq_fanout
  import irq_router_pkg::*;
(
  input  logic [NSRC-1:0]              act_i,
  input  route_t [NSRC-1:0]            route_i,
  output logic [NCORE-1:0][NSRC-1:0]   stat_o,
  output logic [NPAR-1:0]              parent_o
);
  for (genvar c = 0; c < NCORE; c++) begin : g_core
    for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign stat_o[c][i] = act_i[i] & route_i[i].core[c];
    end
    for (genvar k = 0; k < NLINE; k++) begin : g_line
      logic [NSRC-1:0] on_line;
      for (genvar i = 0; i < NSRC; i++) begin : g_sel
        assign on_line[i] = route_i[i].line[k];
      end
      assign parent_o[c*NLINE + k] = |(stat_o[c] & on_line);
    end
  end
endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [NLANE-1:0]  be_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NPAR-1:0]   parent_o
);
  route_t [NSRC-1:0]            route;
  logic [NSRC-1:0]              en_q, pol_q, trig_q, clr, act_raw, pend_q, act;
  logic [NCORE-1:0][NSRC-1:0]   stat;

  irq_regs u_regs (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .be_i, .wdata_i,
    .stat_i (stat),
    .rdata_o,
    .route_o(route),
    .en_o   (en_q),
    .pol_o  (pol_q),
    .trig_o (trig_q),
    .clr_o  (clr)
  );

  irq_src_cond #(.N(NSRC), .STAGES(SYNC_STAGES)) u_cond (
    .clk_i, .rst_ni, .src_i,
    .pol_i (pol_q),
    .trig_i(trig_q),
    .clr_i (clr),
    .act_o (act_raw),
    .pend_o(pend_q)
  );

  assign act = act_raw & en_q;

  irq_fanout u_fan (
    .act_i   (act),
    .route_i (route),
    .stat_o  (stat),
    .parent_o
  );
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk
  import irq_router_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [AW-1:0]     addr_i,
  input logic [NLANE-1:0]  be_i,
  input logic [DW-1:0]     wdata_i,
  input logic [DW-1:0]     rdata_o,
  input logic [NPAR-1:0]   parent_o,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   trig_q,
  input logic [NSRC-1:0]   pend_q
);
  logic wr_set, wr_clr;
  assign wr_set = req_i && we_i && addr_i[AW-1:2] == W_SET;
  assign wr_clr = req_i && we_i && addr_i[AW-1:2] == W_CLR;

  // R3
  clr_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr && be_i == '1 && wdata_i == '1) |=> en_q == '0);

  // R3
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set && be_i == '1) |=> ((en_q & $past(wdata_i)) == $past(wdata_i)));

  // R10
  no_lane_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((wr_set || wr_clr) && be_i == '0) |=> $stable(en_q));

  // R5
  pend_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(trig_q)) == '0));

  // R5
  pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> ((pend_q & $past(wdata_i & lane_mask(be_i))) == '0));

  // R7
  parent_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (parent_o != '0) |-> (en_q != '0));

  // R9
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));
endmodule

bind irq_router irq_router_chk i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .req_i   (req_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .be_i    (be_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .parent_o(parent_o),
  .en_q    (en_q),
  .trig_q  (trig_q),
  .pend_q  (pend_q)
);

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [3:0]  be_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] parent_o;

  irq_router i_irq_router (.*);

  always #5 clk_i = ~clk_i;

  int    n_cmp = 0, n_mis = 0;
  bit    done = 0;
  string cur_tag = "R1";

  // behavioural reference state
  logic [7:0]  m_route [32];
  logic [31:0] m_en, m_pol, m_trig, m_pend, m_s1, m_s2, m_s3, m_rd;
  logic [31:0] t_wm, t_wb, t_hit, t_clr;
  int          t_w;

  function automatic bit m_act(int i);
    if (!m_en[i]) return 0;
    return m_trig[i] ? m_pend[i] : (m_s2[i] ^ m_pol[i]);
  endfunction

  function automatic logic [31:0] m_stat(int c);
    logic [31:0] s = '0;
    for (int i = 0; i < 32; i++) s[i] = m_act(i) && m_route[i][c];
    return s;
  endfunction

  function automatic logic [15:0] m_parent();
    logic [15:0] p = '0;
    for (int i = 0; i < 32; i++)
      if (m_act(i))
        for (int c = 0; c < 4; c++)
          for (int k = 0; k < 4; k++)
            if (m_route[i][c] && m_route[i][4+k]) p[4*c+k] = 1'b1;
    return p;
  endfunction

  function automatic logic [31:0] m_read(int w);
    logic [31:0] r = '0;
    if (w < 8) for (int b = 0; b < 4; b++) r[8*b +: 8] = m_route[4*w+b];
    else if (w == 9 || w == 10 || w == 11) r = m_en;
    else if (w == 12) r = m_pol;
    else if (w == 13) r = m_trig;
    else if (w == 16 || w == 18 || w == 20 || w == 22) r = m_stat((w - 16) / 2);
    return r;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int i = 0; i < 32; i++) m_route[i] = '0;
      m_en = '0; m_pol = '0; m_trig = '0; m_pend = '0;
      m_s1 = '0; m_s2 = '0; m_s3 = '0; m_rd = '0;
    end else begin
      t_w  = int'(addr_i[7:2]);
      for (int b = 0; b < 4; b++) t_wm[8*b +: 8] = {8{be_i[b]}};
      t_wb = wdata_i & t_wm;
      if (req_i && !we_i) m_rd = m_read(t_w);
      t_hit = (m_s2 & ~m_s3 & ~m_pol) | (~m_s2 & m_s3 & m_pol);
      t_clr = (req_i && we_i && t_w == 11) ? t_wb : '0;
      m_pend = (m_pend | (m_trig & t_hit)) & ~t_clr;
      if (req_i && we_i) begin
        if (t_w < 8) begin
          for (int b = 0; b < 4; b++) if (be_i[b]) m_route[4*t_w+b] = wdata_i[8*b +: 8];
        end
        else if (t_w == 10) m_en = m_en | t_wb;
        else if (t_w == 11) m_en = m_en & ~t_wb;
        else if (t_w == 12) m_pol = (m_pol & ~t_wm) | t_wb;
        else if (t_w == 13) m_trig = (m_trig & ~t_wm) | t_wb;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = src_i;
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: got %h expected %h at %0t", cur_tag, what, act, exp, $time);
    end
  endtask

  // compare every cycle, 2 ns after the edge
  always @(posedge clk_i) begin
    #2;
    if (!done) begin
      chk("parent_o", {16'h0, parent_o}, {16'h0, m_parent()});
      chk("rdata_o", rdata_o, m_rd);
    end
  end

  task automatic bus_wr(logic [7:0] a, logic [3:0] b, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; be_i = b; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0; be_i = '0; wdata_i = '0;
  endtask

  task automatic bus_rd(logic [7:0] a);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a; be_i = 4'hF;
    @(negedge clk_i);
    req_i = 0; be_i = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic drive_src(int i, logic v);
    @(negedge clk_i);
    src_i[i] = v;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_cmp++; n_mis++;
      $display("FAIL watchdog: run did not finish, got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    // R1: reset values
    cur_tag = "R1";
    chk("parent after reset", {16'h0, parent_o}, 32'h0);
    bus_rd(8'h00); bus_rd(8'h24); bus_rd(8'h30); bus_rd(8'h34); bus_rd(8'h40);
    idle(2);

    // R2: routing bytes and byte lanes
    cur_tag = "R2";
    bus_wr(8'h00, 4'hF, 32'h184B_2211);
    bus_wr(8'h04, 4'b0010, 32'hFFFF_84FF);
    bus_rd(8'h00); bus_rd(8'h04);
    bus_wr(8'h1C, 4'b1000, 32'hA1EE_EEEE);
    bus_rd(8'h1C);

    // R3: set/clear enable
    cur_tag = "R3";
    bus_wr(8'h28, 4'hF, 32'h0000_0023);
    bus_wr(8'h28, 4'hF, 32'h0000_0100);
    bus_rd(8'h24);
    bus_wr(8'h2C, 4'hF, 32'h0000_0001);
    bus_rd(8'h28); bus_rd(8'h2C);
    bus_wr(8'h2C, 4'hF, 32'hFFFF_FFFF);
    bus_rd(8'h24);

    // R10: byte-lane masking on control words
    cur_tag = "R10";
    bus_wr(8'h28, 4'b0001, 32'hFFFF_FFFF);
    bus_rd(8'h24);
    bus_wr(8'h30, 4'b0100, 32'hFFFF_FFFF);
    bus_rd(8'h30);
    bus_wr(8'h30, 4'hF, 32'h0);

    // R6: synchronizer latency on a level source
    cur_tag = "R6";
    drive_src(0, 1'b1);
    idle(4);
    drive_src(0, 1'b0);
    idle(4);

    // R4: sense inversion in level mode
    cur_tag = "R4";
    bus_wr(8'h30, 4'hF, 32'h0000_0002);
    idle(3);
    drive_src(1, 1'b1);
    idle(4);
    drive_src(1, 1'b0);
    idle(3);

    // R7: fan-out to several cores and several line bits
    cur_tag = "R7";
    drive_src(2, 1'b1);
    idle(3);
    bus_wr(8'h28, 4'hF, 32'h8000_0000);
    drive_src(31, 1'b1);
    idle(3);
    drive_src(2, 1'b0);
    idle(3);

    // R5: sticky pending in edge mode
    cur_tag = "R5";
    bus_wr(8'h34, 4'hF, 32'h0000_0008);
    bus_rd(8'h34);
    drive_src(3, 1'b1);
    drive_src(3, 1'b0);
    idle(6);
    bus_wr(8'h2C, 4'hF, 32'h0000_0008);
    bus_wr(8'h28, 4'hF, 32'h0000_0008);
    idle(3);
    bus_wr(8'h30, 4'hF, 32'h0000_000A);
    drive_src(3, 1'b1);
    idle(4);
    drive_src(3, 1'b0);
    idle(6);

    // R8: per-core status words
    cur_tag = "R8";
    bus_rd(8'h40); bus_rd(8'h48); bus_rd(8'h50); bus_rd(8'h58);

    // R9: unmapped reads, read-only writes, read data hold
    cur_tag = "R9";
    bus_rd(8'h38); bus_rd(8'h60);
    bus_wr(8'h40, 4'hF, 32'hFFFF_FFFF);
    bus_wr(8'h3C, 4'hF, 32'hFFFF_FFFF);
    bus_rd(8'h40); bus_rd(8'h24);
    idle(4);

    done = 1;
    summary();
    $finish;
  end
endmodule